// File: doc/BRIEF.md
# Two-Cycle Memory Bus Master

This block sits on the processor side of a simple parallel memory bus. It runs one transfer at a time over a 16-bit address bus and an 8-bit data bus. Each transfer is a read or a write and takes exactly two clock cycles. A request port takes an address, a direction flag and write data. A one-cycle completion pulse signals the end of the transfer, and for reads the captured byte is presented with it.

During the first cycle the block drives the address. It also drives a set of active-low chip selects, decoded from the upper address nibble. In the second cycle it lowers the read strobe, or it drives the write data, asserts the output enable and lowers the write strobe. Read data is taken on the falling clock edge in the middle of that second cycle. The tri-state data pins are modelled as a separate input, a separate output and an output enable.

Top module: `bus2c_master`

## Requirements
- R1: While reset is high and on the first cycle after it, bus_rd_n, bus_wr_n and every bus_cs_n bit are 1, bus_dout_en and rsp_done are 0, and req_ready is 1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. From that edge on, bus_addr equals the request address, and it stays unchanged through both transfer cycles.
- R3: For a read, bus_rd_n is 0 only in the second transfer cycle (from the second rising edge to the third). bus_wr_n stays 1.
- R4: Read data is the value of bus_din at the falling clock edge inside the second cycle. A change of bus_din after that edge does not alter rsp_rdata.
- R5: For a write, bus_wr_n is 0 and bus_dout_en is 1 only in the second cycle, with bus_dout equal to the request write data. bus_rd_n stays 1.
- R6: bus_dout keeps the written byte in the cycle after bus_wr_n returns high.
- R7: Chip select k (bit k of bus_cs_n) is 0 during both transfer cycles exactly when address bits 15..12 equal 1+k. With the default of two selects, bit 0 covers 0x1000–0x1FFF and bit 1 covers 0x2000–0x2FFF. At most one bit is 0, and all bits are 1 when no transfer is in progress.
- R8: rsp_done is a single-cycle pulse in the cycle after the second transfer cycle. req_ready is 1 in that cycle, so a following request is accepted on the next edge.
- R9: req_ready is 0 during both transfer cycles, and req_valid has no effect then: the address and strobes of the running transfer are unaffected.
- R10: bus_rd_n and bus_wr_n are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Data bus, driven value |
| bus_din | input | 8 | Data bus, received value |
| bus_dout_en | output | 1 | Data bus output enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 2 | Chip selects, active low |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that request fields matter only on the accepting edge, and that bus_din is settled before the mid-cycle falling edge of the second cycle. The stimulus presents requests just after a falling edge. During every first cycle it holds req_valid high with a different address, so that the busy period is exercised. It loads bus_din before the capture edge and overwrites it with the complement one time unit after that edge, which exposes any capture taken at the wrong moment.

// File: rtl/bus2c_pkg.sv
package bus2c_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2
  } phase_t;
endpackage

// File: rtl/bus2c_decode.sv
module bus2c_decode #(
  parameter int AW       = 16,
  parameter int CS_COUNT = 2,
  parameter int CS_BASE  = 1
) (
  input  logic [AW-1:0]       addr,
  output logic [CS_COUNT-1:0] sel_n
);
  localparam int SEL_W  = 4;
  localparam int SEL_LO = AW - SEL_W;

  logic [SEL_W-1:0] top_nib;
  assign top_nib = addr[AW-1:SEL_LO];

  // one region per select: a single upper-nibble value each
  for (genvar k = 0; k < CS_COUNT; k++) begin : g_region
    localparam logic [SEL_W-1:0] MATCH = SEL_W'(CS_BASE + k);
    assign sel_n[k] = (top_nib == MATCH) ? 1'b0 : 1'b1;
  end
endmodule

// File: rtl/bus2c_seq.sv
module bus2c_seq
  import bus2c_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int CS_COUNT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [CS_COUNT-1:0] sel_n,
  output logic                req_ready,
  output logic                rsp_done,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_dout,
  output logic                bus_dout_en,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic [CS_COUNT-1:0] bus_cs_n,
  output logic                cap_en
);
  phase_t        phase;
  logic          wr_q;
  logic [DW-1:0] wd_q;

  assign req_ready = (phase == PH_IDLE);
  assign cap_en    = (phase == PH_STRB) && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      wr_q        <= 1'b0;
      wd_q        <= '0;
      bus_addr    <= '0;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
      bus_rd_n    <= 1'b1;
      bus_wr_n    <= 1'b1;
      bus_cs_n    <= '1;
      rsp_done    <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase    <= PH_ADDR;
            bus_addr <= req_addr;
            bus_cs_n <= sel_n;
            wr_q     <= req_write;
            wd_q     <= req_wdata;
          end
        end
        PH_ADDR: begin
          phase <= PH_STRB;
          if (wr_q) begin
            bus_wr_n    <= 1'b0;
            bus_dout_en <= 1'b1;
            bus_dout    <= wd_q;
          end else begin
            bus_rd_n <= 1'b0;
          end
        end
        PH_STRB: begin
          phase       <= PH_IDLE;
          bus_rd_n    <= 1'b1;
          bus_wr_n    <= 1'b1;
          bus_dout_en <= 1'b0;
          bus_cs_n    <= '1;
          rsp_done    <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus2c_rdcap.sv
module bus2c_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata
);
  // sample in the middle of the strobe cycle
  always_ff @(negedge clk) begin
    if (rst)         rdata <= '0;
    else if (cap_en) rdata <= din;
  end
endmodule

// File: rtl/bus2c_master.sv
module bus2c_master #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int CS_COUNT = 2,
  parameter int CS_BASE  = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_done,
  output logic [DW-1:0]       rsp_rdata,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_dout,
  input  logic [DW-1:0]       bus_din,
  output logic                bus_dout_en,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic [CS_COUNT-1:0] bus_cs_n
);
  logic [CS_COUNT-1:0] sel_n;
  logic                cap_en;

  bus2c_decode #(.AW(AW), .CS_COUNT(CS_COUNT), .CS_BASE(CS_BASE)) u_dec (
    .addr (req_addr),
    .sel_n(sel_n)
  );

  bus2c_seq #(.AW(AW), .DW(DW), .CS_COUNT(CS_COUNT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .sel_n      (sel_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .bus_addr   (bus_addr),
    .bus_dout   (bus_dout),
    .bus_dout_en(bus_dout_en),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_cs_n   (bus_cs_n),
    .cap_en     (cap_en)
  );

  bus2c_rdcap #(.DW(DW)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .cap_en(cap_en),
    .din   (bus_din),
    .rdata (rsp_rdata)
  );
endmodule

// File: rtl/bus2c_checker.sv
module bus2c_checker #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int CS_COUNT = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                req_ready,
  input logic                rsp_done,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_dout,
  input logic                bus_dout_en,
  input logic                bus_rd_n,
  input logic                bus_wr_n,
  input logic [CS_COUNT-1:0] bus_cs_n
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (bus_rd_n && bus_wr_n && (&bus_cs_n) && !bus_dout_en && !rsp_done));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> $stable(bus_addr));

  assert_rd_single_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |=> bus_rd_n);

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |=> (bus_wr_n && !bus_dout_en));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> $stable(bus_dout));

  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  assert_done_after_strb_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> ($past(!bus_rd_n || !bus_wr_n) && req_ready));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> !req_ready);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));
endmodule

bind bus2c_master bus2c_checker #(.AW(AW), .DW(DW), .CS_COUNT(CS_COUNT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .bus_addr   (bus_addr),
  .bus_dout   (bus_dout),
  .bus_dout_en(bus_dout_en),
  .bus_rd_n   (bus_rd_n),
  .bus_wr_n   (bus_wr_n),
  .bus_cs_n   (bus_cs_n)
);

// File: tb/sim_bus2c_master.sv
`timescale 1ns/1ps
module sim_bus2c_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  bus_din = '0;
  logic        req_ready, rsp_done, bus_dout_en, bus_rd_n, bus_wr_n;
  logic [7:0]  rsp_rdata, bus_dout;
  logic [15:0] bus_addr;
  logic [1:0]  bus_cs_n;

  int checks = 0;
  int fails  = 0;
  logic [8:0] exp_q[$];   // bit 8 = read, [7:0] = expected byte

  always #10 clk = ~clk;  // 50 MHz

  bus2c_master u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_dout_en(bus_dout_en),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_cs(input logic [15:0] a);
    logic [1:0] r = 2'b11;
    for (int k = 0; k < 2; k++)
      if (a[15:12] == 4'(1 + k)) r[k] = 1'b0;
    return r;
  endfunction

  // driver: one transfer, starting right after a falling edge
  task automatic xfer(input logic wr, input logic [15:0] a,
                      input logic [7:0] wd, input logic [7:0] rv);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    exp_q.push_back({!wr, rv});
    @(negedge clk);  // first cycle
    chk("R2 addr", 32'(bus_addr), 32'(a));
    chk("R3 rd idle c1", 32'(bus_rd_n), 32'd1);
    chk("R5 wr idle c1", 32'({bus_wr_n, bus_dout_en}), 32'b10);
    chk("R7 cs c1", 32'(bus_cs_n), 32'(exp_cs(a)));
    chk("R9 ready low", 32'(req_ready), 32'd0);
    // R9: competing request while busy
    req_addr = ~a; req_write = !wr; req_wdata = ~wd;
    bus_din = rv;
    @(negedge clk);  // second cycle, capture edge
    chk("R9 addr unchanged", 32'(bus_addr), 32'(a));
    chk("R3 rd strobe", 32'(bus_rd_n), 32'(wr));
    chk("R5 wr strobe", 32'({bus_wr_n, bus_dout_en}), wr ? 32'b01 : 32'b10);
    if (wr) chk("R5 dout", 32'(bus_dout), 32'(wd));
    chk("R10 excl", 32'(bus_rd_n | bus_wr_n), 32'd1);
    chk("R7 cs c2", 32'(bus_cs_n), 32'(exp_cs(a)));
    req_valid = 1'b0;
    #1 bus_din = ~rv;  // R4: late change must be missed
    @(negedge clk);  // done cycle
    chk("R8 done", 32'(rsp_done), 32'd1);
    chk("R8 ready", 32'(req_ready), 32'd1);
    chk("R3 R5 strobes off", 32'({bus_rd_n, bus_wr_n, bus_dout_en}), 32'b110);
    chk("R7 cs off", 32'(bus_cs_n), 32'b11);
    if (wr) chk("R6 dout hold", 32'(bus_dout), 32'(wd));
  endtask

  // monitor: compares completions against the queue
  always @(posedge clk) begin
    #5;
    if (!rst && rsp_done) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 done with no pending request actual=1 expected=0");
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if (e[8]) chk("R4 rdata", 32'(rsp_rdata), 32'(e[7:0]));
      end
    end
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", 32'({bus_rd_n, bus_wr_n, bus_cs_n, bus_dout_en}), 32'b11110);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 32'({req_ready, rsp_done, bus_rd_n, bus_wr_n, bus_cs_n}), 32'b101111);
    xfer(1'b1, 16'h1234, 8'hA5, 8'h00);
    xfer(1'b0, 16'h1234, 8'h00, 8'h3C);
    xfer(1'b1, 16'h2010, 8'h5A, 8'h00);
    xfer(1'b0, 16'h0FFF, 8'h00, 8'hC3);
    xfer(1'b0, 16'h1000, 8'h00, 8'h81);
    xfer(1'b0, 16'h1FFF, 8'h00, 8'h7E);
    xfer(1'b1, 16'h2000, 8'hFF, 8'h00);
    xfer(1'b0, 16'h2FFF, 8'h00, 8'h01);
    xfer(1'b1, 16'h3000, 8'h00, 8'h00);
    xfer(1'b0, 16'hFFFF, 8'h00, 8'hE7);
    @(negedge clk);
    chk("R8 single pulse", 32'(rsp_done), 32'd0);
    chk("R8 queue drained", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule